// File: doc/BRIEF.md
# MDIO Clause 22 Management Initiator

This block is a bus master for the two-wire management interface used to reach external Ethernet PHYs. Software programs a clock divider, loads a 16-bit value for writes, and then writes a frame descriptor with the trigger bit set. The block then sends one complete Clause 22 frame. For a write it drives the data onto the line. For a read it releases the line and shifts in the PHY's answer.

The register port is a plain 32-bit memory-mapped interface. Writes take effect on a single-cycle strobe, and read data follows the address combinationally. On the line side the block drives the management clock and a tri-state data pin, split into an output, an enable and an input. The trigger bit reads back as 1 while a frame is running, so software polls it as a busy flag. A read-OK flag lets a PHY report a failed read by driving 1 in the second turnaround bit.

Top module: `mdio_c22_init`

## Requirements
- R1: After reset, mdc is 0, mdio_oe is 0, the trigger bit reads 0, the divider reads 39 and the status register reads 0.
- R2: The divider sits at offset 0x20, bits 7:0. A write of 0 there is ignored, so the register keeps its old value.
- R3: While a frame runs, every bit lasts 2×(divider+1) clocks. mdc is low for the first half of each bit and high for the second half. mdc stays low when no frame is running.
- R4: A frame is 64 bits, sent MSB first in this order: 32 ones, a 2-bit start code, a 2-bit opcode, a 5-bit PHY address, a 5-bit register address, 2 turnaround bits and 16 data bits. The data to send sits at offset 0x24, bits 15:0.
- R5: The descriptor sits at offset 0x28. Its fields are: bit 31 trigger, bits 20:16 register address, bits 8:4 PHY address, bits 3:2 opcode (01 write, 10 read) and bits 1:0 start code (01). Writing it with bit 31 set starts a frame. Bit 31 then reads 1 for exactly 128×(divider+1) clocks and 0 afterwards.
- R6: In a write frame, mdio_oe stays 1 for all 64 bits and the turnaround is sent as 1 then 0.
- R7: In a read frame, mdio_oe is 0 from bit 46 through bit 63. Data bits are sampled on the rising edge of mdc and appear at offset 0x2C, bits 15:0.
- R8: Status bit 24 (read-OK) is the inverse of the mdio_i level sampled in the second turnaround bit (bit 47) of a read.
- R9: A write to the descriptor while the trigger bit is 1 changes neither the running frame nor the stored fields.
- R10: The status register changes only when a read frame completes. A write frame leaves it unchanged.
- R11: mdio_o changes only at the clock edge where mdc falls, or at the start of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data for bus_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable |
| mdio_i | input | 1 | Data line input |

## Verification
A bit counter that has slipped shows at once on the line. The output enable drops at the wrong mdc period, or a field bit appears one period early or late. The per-clock model catches this in the first half-bit after the fault. A divider or phase fault shows as an mdc edge one clock off, in the very cycle it happens. A wrong capture position or turnaround sample stays hidden until the frame ends, when the status read shows shifted data or an inverted read-OK. A busy flag that clears too early shows as bit 31 reading 0 before 128×(divider+1) clocks have passed.

// File: rtl/mdio_c22_pkg.sv
`timescale 1ns/1ps
package mdio_c22_pkg;

    localparam int FRAME_LEN = 64;
    localparam int PRE_LEN   = 32;
    localparam int TA_POS    = 46;
    localparam int DATA_W    = 16;

    localparam logic [7:0] OFF_PRESCALE = 8'h20;
    localparam logic [7:0] OFF_WDATA    = 8'h24;
    localparam logic [7:0] OFF_CFG      = 8'h28;
    localparam logic [7:0] OFF_STAT     = 8'h2C;

    localparam int TRIG_BIT = 31;
    localparam int OK_BIT   = 24;

    typedef enum logic [1:0] {
        OP_NONE0 = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_NONE3 = 2'b11
    } mdio_op_e;

    typedef struct packed {
        logic [4:0] reg_a;
        logic [4:0] phy_a;
        mdio_op_e   op;
        logic [1:0] st;
    } frame_cfg_t;

    function automatic frame_cfg_t unpack_cfg(input logic [31:0] w);
        frame_cfg_t c;
        c.reg_a = w[20:16];
        c.phy_a = w[8:4];
        c.op    = mdio_op_e'(w[3:2]);
        c.st    = w[1:0];
        return c;
    endfunction

    function automatic logic [31:0] pack_cfg(input logic busy, input frame_cfg_t c);
        return {busy, 10'b0, c.reg_a, 7'b0, c.phy_a, c.op, c.st};
    endfunction

    function automatic logic [FRAME_LEN-1:0] build_frame(input frame_cfg_t c,
                                                         input logic [DATA_W-1:0] d);
        return {{PRE_LEN{1'b1}}, c.st, c.op, c.phy_a, c.reg_a, 2'b10, d};
    endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
`timescale 1ns/1ps
module mdio_mdc_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise,
    output logic             fall
);
    logic [DIV_W-1:0] cnt_q;
    logic             half_end;

    // a half period is div+1 clocks
    assign half_end = run && (cnt_q >= div);
    assign rise     = half_end && !mdc;
    assign fall     = half_end && mdc;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
            mdc   <= 1'b0;
        end else if (half_end) begin
            cnt_q <= '0;
            mdc   <= ~mdc;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/mdio_frame_eng.sv
`timescale 1ns/1ps
module mdio_frame_eng #(
    parameter int FRAME_LEN = 64,
    parameter int TA_POS    = 46,
    parameter int DATA_W    = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rd_mode,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_i,
    output logic                 mdio_o,
    output logic                 mdio_oe,
    output logic                 busy,
    output logic                 done,
    output logic [DATA_W-1:0]    cap_data,
    output logic                 cap_ok
);
    localparam int IDX_W    = $clog2(FRAME_LEN);
    localparam int LAST     = FRAME_LEN - 1;
    localparam int TA2_POS  = TA_POS + 1;
    localparam int DATA_POS = TA_POS + 2;

    logic [FRAME_LEN-1:0] sh_q;
    logic [IDX_W-1:0]     idx_q;
    logic                 busy_q;
    logic                 rd_q;

    assign busy    = busy_q;
    assign done    = busy_q && fall && (idx_q == IDX_W'(LAST));
    assign mdio_oe = busy_q && (!rd_q || (idx_q < IDX_W'(TA_POS)));
    assign mdio_o  = mdio_oe & sh_q[LAST];

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q     <= '0;
            idx_q    <= '0;
            busy_q   <= 1'b0;
            rd_q     <= 1'b0;
            cap_data <= '0;
            cap_ok   <= 1'b0;
        end else if (!busy_q) begin
            if (start) begin
                sh_q   <= frame;
                idx_q  <= '0;
                busy_q <= 1'b1;
                rd_q   <= rd_mode;
            end
        end else begin
            if (fall) begin
                if (done) begin
                    busy_q <= 1'b0;
                end else begin
                    sh_q  <= {sh_q[LAST-1:0], 1'b0};
                    idx_q <= idx_q + 1'b1;
                end
            end
            if (rise) begin
                if (idx_q == IDX_W'(TA2_POS))
                    cap_ok <= ~mdio_i;
                if (idx_q >= IDX_W'(DATA_POS))
                    cap_data <= {cap_data[DATA_W-2:0], mdio_i};
            end
        end
    end
endmodule

// File: rtl/mdio_c22_init.sv
`timescale 1ns/1ps
module mdio_c22_init
    import mdio_c22_pkg::*;
#(
    parameter int ADDR_W  = 8,
    parameter int DIV_W   = 8,
    parameter int DEF_DIV = 39
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    logic [DIV_W-1:0]  div_q;
    logic [DATA_W-1:0] wdat_q;
    frame_cfg_t        cfg_q;
    logic [DATA_W-1:0] stat_data_q;
    logic              stat_ok_q;

    logic              busy_w, done_w, rise_w, fall_w, launch_w;
    logic              sel_div, sel_wd, sel_cfg, sel_st;
    frame_cfg_t        new_cfg;
    logic [DATA_W-1:0] cap_data_w;
    logic              cap_ok_w;

    assign sel_div  = bus_addr == ADDR_W'(OFF_PRESCALE);
    assign sel_wd   = bus_addr == ADDR_W'(OFF_WDATA);
    assign sel_cfg  = bus_addr == ADDR_W'(OFF_CFG);
    assign sel_st   = bus_addr == ADDR_W'(OFF_STAT);
    assign new_cfg  = unpack_cfg(bus_wdata);
    assign launch_w = bus_wr && sel_cfg && bus_wdata[TRIG_BIT] && !busy_w;

    always_ff @(posedge clk) begin
        if (rst) begin
            div_q       <= DIV_W'(DEF_DIV);
            wdat_q      <= '0;
            cfg_q       <= '0;
            stat_data_q <= '0;
            stat_ok_q   <= 1'b0;
        end else begin
            if (bus_wr && sel_div && (bus_wdata[DIV_W-1:0] != '0))
                div_q <= bus_wdata[DIV_W-1:0];
            if (bus_wr && sel_wd)
                wdat_q <= bus_wdata[DATA_W-1:0];
            if (bus_wr && sel_cfg && !busy_w)
                cfg_q <= new_cfg;
            if (done_w && (cfg_q.op == OP_READ)) begin
                stat_data_q <= cap_data_w;
                stat_ok_q   <= cap_ok_w;
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (sel_div)      bus_rdata[DIV_W-1:0]  = div_q;
        else if (sel_wd)  bus_rdata[DATA_W-1:0] = wdat_q;
        else if (sel_cfg) bus_rdata = pack_cfg(busy_w, cfg_q);
        else if (sel_st) begin
            bus_rdata[DATA_W-1:0] = stat_data_q;
            bus_rdata[OK_BIT]     = stat_ok_q;
        end
    end

    mdio_mdc_gen #(.DIV_W(DIV_W)) u_mdc (
        .clk  (clk),
        .rst  (rst),
        .run  (busy_w),
        .div  (div_q),
        .mdc  (mdc),
        .rise (rise_w),
        .fall (fall_w)
    );

    mdio_frame_eng #(.FRAME_LEN(FRAME_LEN), .TA_POS(TA_POS), .DATA_W(DATA_W)) u_eng (
        .clk      (clk),
        .rst      (rst),
        .start    (launch_w),
        .frame    (build_frame(new_cfg, wdat_q)),
        .rd_mode  (new_cfg.op == OP_READ),
        .rise     (rise_w),
        .fall     (fall_w),
        .mdio_i   (mdio_i),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .busy     (busy_w),
        .done     (done_w),
        .cap_data (cap_data_w),
        .cap_ok   (cap_ok_w)
    );
endmodule

// File: rtl/mdio_c22_init_chk.sv
`timescale 1ns/1ps
module mdio_c22_init_chk #(
    parameter int DIV_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             mdc,
    input logic             mdio_o,
    input logic             mdio_oe,
    input logic             busy,
    input logic [DIV_W-1:0] div,
    input logic [16:0]      cfg_bits,
    input logic [16:0]      stat
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !mdio_oe)); // R1

    AST_MDC_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        $rose(mdc) |-> busy); // R3

    AST_OUT_ON_FALL: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !$fell(mdc)) |-> $stable(mdio_o)); // R11

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_bits)); // R9

    AST_STAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$fell(busy) |-> $stable(stat)); // R10

    AST_DIV_NONZERO: assert property (@(posedge clk) disable iff (rst)
        div != '0); // R2
endmodule

bind mdio_c22_init mdio_c22_init_chk #(.DIV_W(DIV_W)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .mdc      (mdc),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .busy     (busy_w),
    .div      (div_q),
    .cfg_bits (cfg_q),
    .stat     ({stat_ok_q, stat_data_q})
);

// File: tb/mdio_c22_init_tb_top.sv
`timescale 1ns/1ps
module mdio_c22_init_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int checks = 0;
    int fails  = 0;
    int cur_div = 39;
    logic [31:0] rv;

    always #2.5 clk = ~clk;

    mdio_c22_init dut_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] cfg_word(input logic trig, input logic [4:0] ra,
                                             input logic [4:0] phy, input logic [1:0] op);
        return {trig, 10'b0, ra, 7'b0, phy, op, 2'b01};
    endfunction

    // per-clock reference model of one frame with a behavioural PHY
    task automatic run_frame(input logic rd, input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] data, input logic ta2, input logic poke);
        int h;
        int total;
        logic [1:0]  op;
        logic [63:0] exp_frame;
        h = cur_div + 1;
        total = 128 * h;
        op = rd ? 2'b10 : 2'b01;
        exp_frame = {32'hFFFF_FFFF, 2'b01, op, phy, ra, 2'b10, rd ? 16'h0 : data};
        bus_addr  = 8'h28;
        bus_wdata = cfg_word(1'b1, ra, phy, op);
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
        for (int k = 0; k < total; k++) begin
            int   b;
            logic eo, em;
            b  = k / (2 * h);
            eo = !rd || (b < 46);
            em = (k % (2 * h)) >= h;
            chk("R3 mdc phase", {31'b0, mdc}, {31'b0, em});
            chk(rd ? "R7 oe" : "R6 oe", {31'b0, mdio_oe}, {31'b0, eo});
            if (eo) chk("R4 bit value", {31'b0, mdio_o}, {31'b0, exp_frame[63-b]});
            chk("R5 busy bit", {31'b0, bus_rdata[31]}, 32'd1);
            if (rd && b == 47)      mdio_i = ta2;
            else if (rd && b >= 48) mdio_i = data[63-b];
            else                    mdio_i = 1'b1;
            if (poke && k == 10) begin
                bus_wdata = cfg_word(1'b1, 5'h03, 5'h07, 2'b10);
                bus_wr    = 1'b1;
            end else begin
                bus_wr = 1'b0;
            end
            @(posedge clk);
            @(negedge clk);
        end
        bus_wr = 1'b0;
        mdio_i = 1'b1;
        chk("R5 busy cleared", {31'b0, bus_rdata[31]}, 32'd0);
        chk("R3 mdc idle", {31'b0, mdc}, 32'd0);
        chk("R1 oe idle", {31'b0, mdio_oe}, 32'd0);
    endtask

    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bus_wr = 1'b0; bus_addr = 8'h0; bus_wdata = '0; mdio_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk("R1 mdc", {31'b0, mdc}, 32'd0);
        chk("R1 oe", {31'b0, mdio_oe}, 32'd0);
        bus_read(8'h28, rv); chk("R1 trigger", {31'b0, rv[31]}, 32'd0);
        bus_read(8'h20, rv); chk("R1 divider", rv, 32'd39);
        bus_read(8'h2C, rv); chk("R1 status", rv, 32'd0);
        // R2 divider register
        bus_write(8'h20, 32'd0);
        bus_read(8'h20, rv); chk("R2 zero ignored", rv, 32'd39);
        bus_write(8'h20, 32'd1); cur_div = 1;
        bus_read(8'h20, rv); chk("R2 divider write", rv, 32'd1);
        // R4 / R6 write frame
        bus_write(8'h24, 32'h0000_A5C3);
        bus_read(8'h24, rv); chk("R4 write data reg", rv, 32'h0000_A5C3);
        run_frame(1'b0, 5'h05, 5'h11, 16'hA5C3, 1'b0, 1'b0);
        bus_read(8'h28, rv); chk("R5 cfg readback", rv, cfg_word(1'b0, 5'h11, 5'h05, 2'b01));
        bus_read(8'h2C, rv); chk("R10 status after write", rv, 32'd0);
        // R7 / R8 read frame, PHY acknowledges
        run_frame(1'b1, 5'h1F, 5'h02, 16'h1234, 1'b0, 1'b0);
        bus_read(8'h2C, rv); chk("R7 R8 read status", rv, 32'h0100_1234);
        // R9 / R10 write frame with descriptor poke while busy
        bus_write(8'h24, 32'h0000_0F0F);
        run_frame(1'b0, 5'h0A, 5'h03, 16'h0F0F, 1'b0, 1'b1);
        bus_read(8'h28, rv); chk("R9 cfg unchanged", rv, cfg_word(1'b0, 5'h03, 5'h0A, 2'b01));
        bus_read(8'h2C, rv); chk("R10 status kept", rv, 32'h0100_1234);
        // R8 failing read at divider 3
        bus_write(8'h20, 32'd3); cur_div = 3;
        run_frame(1'b1, 5'h00, 5'h1F, 16'hBEEF, 1'b1, 1'b0);
        bus_read(8'h2C, rv); chk("R8 read fail flag", rv, 32'h0000_BEEF);
        // R3 default divider rate
        bus_write(8'h20, 32'd39); cur_div = 39;
        run_frame(1'b1, 5'h11, 5'h04, 16'h8001, 1'b0, 1'b0);
        bus_read(8'h2C, rv); chk("R7 read at div 39", rv, 32'h0100_8001);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule